// File: doc/BRIEF.md
# Carry-Flag Bit Manipulation Unit

This unit carries out single-bit operations for a small 4-bit controller datapath. Each operation names one bit of a 256-word by 4-bit data memory held inside the unit. The bit is found through one of three addressing modes. The selected bit is then either folded into a carry flag by AND, OR or XOR, or tested. A test on a set bit clears that bit in memory and raises a skip request for the surrounding sequencer.

An operation starts with a one-cycle `start` strobe, which carries the operation code, the addressing mode, an 8-bit immediate field, a 2-bit bit index and the H and L pointer nibbles. At the next clock edge the unit reads the word, computes the result and commits it. From there `done` is high for one cycle, together with the new carry, the skip flag and, when a bit was cleared, a description of the memory write-back.

A separate loader port fills the memory before operations run. It writes only while the unit is idle.

Top module: `cf_bitop_unit`

## Requirements
- R1: After reset, `cy`, `done`, `skip` and `wb_en` are 0, and every memory word reads as 0.
- R2: A `start` sampled high while idle at clock edge k makes `done` high for exactly one cycle, following edge k+1. The updated `cy`, `skip` and write-back outputs appear in that same cycle.
- R3: Operation codes 0, 1 and 2 set `cy` to `cy AND b`, `cy OR b` and `cy XOR b`, where b is the addressed bit. These operations never write memory and never assert `skip`.
- R4: Operation code 3 (test-and-clear) on a bit equal to 1 does three things. It asserts `skip` and `wb_en` with `done`. It presents the word address on `wb_addr` and the word with that bit cleared on `wb_data`. It stores the cleared word in memory. It leaves `cy` unchanged.
- R5: Test-and-clear on a bit equal to 0 leaves `skip` and `wb_en` at 0, writes nothing and leaves `cy` unchanged.
- R6: Mode 0 (direct) addresses word `imm[7:0]` and bit `bit_sel`. Mode 3 behaves the same as mode 0.
- R7: Mode 1 (pointer-indexed) addresses word {`imm[7:2]`, `l_reg[3:2]`} and bit `l_reg[1:0]`. It ignores `bit_sel` and `imm[1:0]`.
- R8: Mode 2 (H-relative) addresses word {`h_reg`, `imm[3:0]`} and bit `bit_sel`. It ignores `imm[7:4]`.
- R9: A `start` sampled while an operation is in flight is ignored. It produces no second `done` and no change to `cy`.
- R10: A loader write (`ld_we`) sampled while idle stores `ld_data` at `ld_addr`. A loader write sampled while an operation is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that launches an operation |
| op | input | 2 | 0 AND, 1 OR, 2 XOR, 3 test-and-clear |
| mode | input | 2 | 0 direct, 1 pointer-indexed, 2 H-relative, 3 as direct |
| imm | input | 8 | Immediate address field |
| bit_sel | input | 2 | Bit index for direct and H-relative modes |
| h_reg | input | 4 | H pointer nibble |
| l_reg | input | 4 | L pointer nibble |
| ld_we | input | 1 | Loader write enable |
| ld_addr | input | 8 | Loader word address |
| ld_data | input | 4 | Loader word data |
| cy | output | 1 | Carry flag |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | Skip request from a successful test-and-clear |
| wb_en | output | 1 | Memory write-back happened this operation |
| wb_addr | output | 8 | Word address of the write-back |
| wb_data | output | 4 | Word value written back |

## Verification
Every result is due in a single cycle: the one following the edge after the edge that sampled `start`. In that cycle `done`, `cy`, `skip` and the write-back fields all change together. A loader write takes effect at its own edge, so an operation started at the same edge already reads the new word.

The bench drives inputs on falling edges and steps its reference model on rising edges. It compares every output on the falling edge, when the committed values are stable. Each directed scenario reads its expected values in exactly that result cycle, two falling edges after it raises `start`.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_XOR  = 2'd2,
        OP_TCLR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        AM_DIRECT = 2'd0,
        AM_PTR    = 2'd1,
        AM_HREL   = 2'd2,
        AM_ALT    = 2'd3
    } amode_e;

endpackage

// File: rtl/cfb_addr_resolve.sv
module cfb_addr_resolve
    import cfb_pkg::*;
#(
    parameter int NIB = 4,
    localparam int AW = 2 * NIB,
    localparam int BW = $clog2(NIB)
) (
    input  amode_e          mode,
    input  logic [AW-1:0]   imm,
    input  logic [BW-1:0]   bit_sel,
    input  logic [NIB-1:0]  h_ptr,
    input  logic [NIB-1:0]  l_ptr,
    output logic [AW-1:0]   word_addr,
    output logic [BW-1:0]   bit_pos
);

    always_comb begin
        unique case (mode)
            AM_PTR: begin
                // upper immediate bits select a block, L picks word and bit
                word_addr = {imm[AW-1:NIB-BW], l_ptr[NIB-1:BW]};
                bit_pos   = l_ptr[BW-1:0];
            end
            AM_HREL: begin
                word_addr = {h_ptr, imm[NIB-1:0]};
                bit_pos   = bit_sel;
            end
            default: begin
                word_addr = imm;
                bit_pos   = bit_sel;
            end
        endcase
    end

endmodule

// File: rtl/cfb_bit_alu.sv
module cfb_bit_alu
    import cfb_pkg::*;
#(
    parameter int NIB = 4,
    localparam int BW = $clog2(NIB)
) (
    input  op_e             op,
    input  logic [NIB-1:0]  word,
    input  logic [BW-1:0]   bit_pos,
    input  logic            cy_in,
    output logic            cy_out,
    output logic            hit,
    output logic [NIB-1:0]  cleared
);

    logic           bit_val;
    logic [NIB-1:0] bit_mask;

    always_comb begin
        bit_mask = '0;
        for (int i = 0; i < NIB; i++) begin
            bit_mask[i] = (bit_pos == BW'(i));
        end
        bit_val = |(word & bit_mask);
        cleared = word & ~bit_mask;
        hit     = 1'b0;
        unique case (op)
            OP_AND:  cy_out = cy_in & bit_val;
            OP_OR:   cy_out = cy_in | bit_val;
            OP_XOR:  cy_out = cy_in ^ bit_val;
            default: begin
                cy_out = cy_in;
                hit    = bit_val;
            end
        endcase
    end

endmodule

// File: rtl/cfb_word_mem.sv
module cfb_word_mem #(
    parameter int NIB = 4,
    parameter int AW  = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [NIB-1:0]  wdata,
    input  logic [AW-1:0]   raddr,
    output logic [NIB-1:0]  rdata
);

    logic [NIB-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/cf_bitop_unit.sv
module cf_bitop_unit
    import cfb_pkg::*;
#(
    parameter int NIB = 4,
    localparam int AW = 2 * NIB,
    localparam int BW = $clog2(NIB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [1:0]      mode,
    input  logic [AW-1:0]   imm,
    input  logic [BW-1:0]   bit_sel,
    input  logic [NIB-1:0]  h_reg,
    input  logic [NIB-1:0]  l_reg,
    input  logic            ld_we,
    input  logic [AW-1:0]   ld_addr,
    input  logic [NIB-1:0]  ld_data,
    output logic            cy,
    output logic            done,
    output logic            skip,
    output logic            wb_en,
    output logic [AW-1:0]   wb_addr,
    output logic [NIB-1:0]  wb_data
);

    typedef struct packed {
        logic           busy;
        op_e            op;
        logic [AW-1:0]  addr;
        logic [BW-1:0]  bitp;
        logic           cy;
        logic           done;
        logic           skip;
        logic           wb_en;
        logic [AW-1:0]  wb_addr;
        logic [NIB-1:0] wb_data;
    } state_t;

    state_t st_d, st_q;

    logic [AW-1:0]  res_addr;
    logic [BW-1:0]  res_bit;
    logic [NIB-1:0] rd_word;
    logic           alu_cy;
    logic           alu_hit;
    logic [NIB-1:0] alu_clr;
    logic           mem_we_d;
    logic [AW-1:0]  mem_waddr_d;
    logic [NIB-1:0] mem_wdata_d;

    cfb_addr_resolve #(.NIB(NIB)) u_resolve (
        .mode      (amode_e'(mode)),
        .imm       (imm),
        .bit_sel   (bit_sel),
        .h_ptr     (h_reg),
        .l_ptr     (l_reg),
        .word_addr (res_addr),
        .bit_pos   (res_bit)
    );

    cfb_word_mem #(.NIB(NIB), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we_d),
        .waddr (mem_waddr_d),
        .wdata (mem_wdata_d),
        .raddr (st_q.addr),
        .rdata (rd_word)
    );

    cfb_bit_alu #(.NIB(NIB)) u_alu (
        .op      (st_q.op),
        .word    (rd_word),
        .bit_pos (st_q.bitp),
        .cy_in   (st_q.cy),
        .cy_out  (alu_cy),
        .hit     (alu_hit),
        .cleared (alu_clr)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.skip   = 1'b0;
        st_d.wb_en  = 1'b0;
        mem_we_d    = 1'b0;
        mem_waddr_d = ld_addr;
        mem_wdata_d = ld_data;
        if (st_q.busy) begin
            // commit cycle: new start and loader writes are not taken
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.cy   = alu_cy;
            st_d.skip = alu_hit;
            if (alu_hit) begin
                st_d.wb_en   = 1'b1;
                st_d.wb_addr = st_q.addr;
                st_d.wb_data = alu_clr;
                mem_we_d     = 1'b1;
                mem_waddr_d  = st_q.addr;
                mem_wdata_d  = alu_clr;
            end
        end else begin
            mem_we_d = ld_we;
            if (start) begin
                st_d.busy = 1'b1;
                st_d.op   = op_e'(op);
                st_d.addr = res_addr;
                st_d.bitp = res_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cy      = st_q.cy;
    assign done    = st_q.done;
    assign skip    = st_q.skip;
    assign wb_en   = st_q.wb_en;
    assign wb_addr = st_q.wb_addr;
    assign wb_data = st_q.wb_data;

endmodule

// File: rtl/cfb_bitop_chk.sv
module cfb_bitop_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic cy,
    input logic done,
    input logic skip,
    input logic wb_en
);

    // R2: an accepted start yields done two edges later
    assert_start_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##2 done);

    // R2: done never lasts two cycles
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: carry only moves in a non-skip completion cycle
    assert_cy_moves_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cy) |-> (done && !skip));

    // R4: a write-back always accompanies a skip and vice versa
    assert_wb_matches_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en == skip);

    // R5: skip only appears with a completion
    assert_skip_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> done);

    // R9: a start while busy does not extend the operation
    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !busy);

endmodule

bind cf_bitop_unit cfb_bitop_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (st_q.busy),
    .cy    (cy),
    .done  (done),
    .skip  (skip),
    .wb_en (wb_en)
);

// File: tb/cf_bitop_unit_tb_top.sv
module cf_bitop_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [1:0] op, mode;
    logic [7:0] imm;
    logic [1:0] bit_sel;
    logic [3:0] h_reg, l_reg;
    logic       ld_we;
    logic [7:0] ld_addr;
    logic [3:0] ld_data;
    logic       cy, done, skip, wb_en;
    logic [7:0] wb_addr;
    logic [3:0] wb_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cf_bitop_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode),
        .imm(imm), .bit_sel(bit_sel), .h_reg(h_reg), .l_reg(l_reg),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .cy(cy), .done(done), .skip(skip), .wb_en(wb_en),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_mem [256];
    int m_busy, m_cy, m_done, m_skip, m_wben, m_op, m_addr, m_bit, m_wbaddr, m_wbdata, m_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_busy = 0; m_cy = 0; m_done = 0; m_skip = 0; m_wben = 0;
            m_wbaddr = 0; m_wbdata = 0; m_op = 0; m_addr = 0; m_bit = 0;
        end else begin
            m_done = 0; m_skip = 0; m_wben = 0;
            if (m_busy != 0) begin
                m_busy = 0;
                m_done = 1;
                m_b = (m_mem[m_addr] >> m_bit) & 1;
                case (m_op)
                    0: m_cy = m_cy & m_b;
                    1: m_cy = m_cy | m_b;
                    2: m_cy = m_cy ^ m_b;
                    default: if (m_b != 0) begin
                        m_mem[m_addr] = m_mem[m_addr] & ~(1 << m_bit) & 15;
                        m_skip = 1; m_wben = 1;
                        m_wbaddr = m_addr; m_wbdata = m_mem[m_addr];
                    end
                endcase
            end else begin
                if (ld_we) m_mem[ld_addr] = ld_data;
                if (start) begin
                    m_busy = 1;
                    m_op = op;
                    if (mode == 2'd1) begin
                        m_addr = (imm & 8'hFC) | ((l_reg >> 2) & 3);
                        m_bit  = l_reg & 3;
                    end else if (mode == 2'd2) begin
                        m_addr = h_reg * 16 + (imm & 15);
                        m_bit  = bit_sel;
                    end else begin
                        m_addr = imm;
                        m_bit  = bit_sel;
                    end
                end
            end
        end
    end

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(done == m_done[0], "R2 done vs model", done, m_done);
            chk(cy == m_cy[0], "R3 cy vs model", cy, m_cy);
            chk(skip == m_skip[0], "R4 skip vs model", skip, m_skip);
            chk(wb_en == m_wben[0], "R4 wb_en vs model", wb_en, m_wben);
            if (m_wben != 0) begin
                chk(wb_addr == 8'(m_wbaddr), "R4 wb_addr vs model", wb_addr, m_wbaddr);
                chk(wb_data == 4'(m_wbdata), "R4 wb_data vs model", wb_data, m_wbdata);
            end
        end
    end

    task automatic issue(input int o, input int md, input int im, input int bs, input int h, input int l);
        @(negedge clk);
        start = 1'b1; op = 2'(o); mode = 2'(md); imm = 8'(im);
        bit_sel = 2'(bs); h_reg = 4'(h); l_reg = 4'(l);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input int a, input int d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 8'(a); ld_data = 4'(d);
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL R2 watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op = '0; mode = '0; imm = '0; bit_sel = '0;
        h_reg = '0; l_reg = '0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cy == 1'b0 && done == 1'b0, "R1 reset cy/done", {cy, done}, 0);
        chk(skip == 1'b0 && wb_en == 1'b0, "R1 reset skip/wb_en", {skip, wb_en}, 0);
        issue(3, 0, 8'h10, 1, 0, 0);
        chk(done && !skip, "R1 cleared memory gives no skip", {done, skip}, 2);

        load(8'h35, 4'b0100);
        issue(1, 0, 8'h35, 2, 0, 0);
        chk(cy == 1'b1, "R6 direct OR of set bit", cy, 1);
        chk(done == 1'b1, "R2 done in result cycle", done, 1);
        issue(0, 0, 8'h35, 0, 0, 0);
        chk(cy == 1'b0, "R3 AND with clear bit", cy, 0);
        issue(1, 3, 8'h35, 2, 0, 0);
        chk(cy == 1'b1, "R6 mode 3 acts as direct", cy, 1);
        issue(0, 0, 8'h35, 3, 0, 0);
        chk(cy == 1'b0, "R3 AND clears carry", cy, 0);

        load(8'hA6, 4'b1000);
        issue(2, 1, 8'hA4, 0, 0, 4'b1011);
        chk(cy == 1'b1, "R7 pointer XOR sets", cy, 1);
        issue(2, 1, 8'hA4, 0, 0, 4'b1011);
        chk(cy == 1'b0, "R3 XOR toggles back", cy, 0);
        issue(1, 1, 8'hA7, 1, 0, 4'b1011);
        chk(cy == 1'b1, "R7 imm low bits and bit_sel ignored", cy, 1);

        load(8'h7C, 4'b0010);
        issue(3, 2, 8'hBC, 1, 7, 0);
        chk(skip == 1'b1 && wb_en == 1'b1, "R8 H-relative test hit", {skip, wb_en}, 3);
        chk(wb_addr == 8'h7C && wb_data == 4'h0, "R4 write-back word", {wb_addr, wb_data}, 12'h7C0);
        chk(cy == 1'b1, "R4 carry unchanged by test", cy, 1);
        issue(3, 2, 8'hBC, 1, 7, 0);
        chk(skip == 1'b0 && wb_en == 1'b0, "R5 cleared bit gives no skip", {skip, wb_en}, 0);
        chk(cy == 1'b1, "R5 carry unchanged by miss", cy, 1);

        // busy window: second start must be dropped
        @(negedge clk);
        start = 1'b1; op = 2'd0; mode = 2'd0; imm = 8'h10; bit_sel = 2'd0;
        @(negedge clk);
        op = 2'd1; imm = 8'h35; bit_sel = 2'd2;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && cy == 1'b0, "R9 first op result", {done, cy}, 2);
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0 && cy == 1'b0, "R9 busy start ignored", {done, cy}, 0);

        // loader write during busy is dropped
        @(negedge clk);
        start = 1'b1; op = 2'd0; mode = 2'd0; imm = 8'h10; bit_sel = 2'd0;
        @(negedge clk);
        start = 1'b0; ld_we = 1'b1; ld_addr = 8'h50; ld_data = 4'hF;
        @(negedge clk);
        ld_we = 1'b0;
        issue(3, 0, 8'h50, 0, 0, 0);
        chk(skip == 1'b0, "R10 busy load ignored", skip, 0);
        load(8'h50, 4'b1000);
        issue(3, 0, 8'h50, 3, 0, 0);
        chk(skip == 1'b1 && wb_data == 4'h0, "R10 idle load stored", {skip, wb_data}, 16);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule